// File: doc/BRIEF.md
# Masked Broadcast SIMD Array

This block is an array of simple processing elements (PEs) driven by a single external controller. Each PE holds one 32-bit data record and one enable flag. The controller presents one instruction per cycle, made of an opcode and an immediate. Every PE executes that same instruction. The PEs have no sequencing logic of their own.

A conditional over all records takes two broadcast passes over one mask:
- a compare writes each PE's flag;
- an arithmetic step updates only the PEs whose flag is set;
- a mask inversion flips every flag;
- a second arithmetic step updates the other group.

A typical workload scales each value in Q16.16 fixed point. Values above 100000 are multiplied by about 1.05 (immediate 68813). All other values are multiplied by about 1.10 (immediate 72090).

Records move in and out through a shift chain. Input data enters PE0, and PE(N-1) is visible at the serial output. A registered output reports whether any PE is currently enabled.

Top module: `simd_array`

## Requirements
- R1: After reset every PE value is 0, every flag is 1, `ser_data_o` is 0 and `any_en_o` is 1.
- R2: Opcode 1 (shift) loads `ser_data_i` into PE0 and moves each PE k's value into PE k+1, whatever the flags. `ser_data_o` always shows PE N-1.
- R3: Opcode 2 (compare) sets each PE's flag to (value > imm), using an unsigned comparison. It writes every PE, including disabled ones.
- R4: Opcode 3 (multiply) replaces the value of each enabled PE with bits [47:16] of the unsigned 64-bit product value*imm.
- R5: A PE whose flag is 0 keeps its value unchanged under opcode 3.
- R6: Opcode 4 inverts every flag.
- R7: Opcode 5 sets every flag to 1.
- R8: The following change no value and no flag:
  - opcode 0;
  - opcodes 6 and 7;
  - any opcode while `instr_valid_i` is 0.
- R9: `any_en_o` equals the OR of all flags, one clock after the flags take their value.
- R10: The sequence compare 100000, multiply 68813, invert, multiply 72090 leaves each PE holding the scaled value of its own branch. Values above 100000 take the first branch; all other values take the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 3 | Broadcast opcode |
| imm_i | input | 32 | Broadcast immediate |
| ser_data_i | input | 32 | Serial record input into PE0 |
| ser_data_o | output | 32 | Value of the last PE |
| any_en_o | output | 1 | Registered OR of all PE flags |

## Verification
Two things can change in the same cycle: a new mask instruction and the reduction output. The reduction output is still reporting the flags of the previous cycle while the new instruction alters them.

The bench provokes this overlap in two ways:
- a compare whose threshold disables every PE, followed at once by a mask inversion, with `any_en_o` sampled cycle by cycle;
- a compare issued while all flags are already cleared.

`any_en_o` must trace the expected flag OR with exactly one cycle of lag. Disabled PEs must still take the compare result.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_SHIFT = 3'd1;
  localparam logic [2:0] OP_CMPGT = 3'd2;
  localparam logic [2:0] OP_MULQ  = 3'd3;
  localparam logic [2:0] OP_INVM  = 3'd4;
  localparam logic [2:0] OP_SETM  = 3'd5;

  typedef struct packed {
    logic shift;
    logic cmp;
    logic mul;
    logic inv;
    logic set;
  } pe_ctrl_t;
endpackage

// File: rtl/simd_decode.sv
module simd_decode
  import simd_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] op_i,
  output pe_ctrl_t   ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    if (valid_i) begin
      unique case (op_i)
        OP_SHIFT: ctrl_o.shift = 1'b1;
        OP_CMPGT: ctrl_o.cmp   = 1'b1;
        OP_MULQ:  ctrl_o.mul   = 1'b1;
        OP_INVM:  ctrl_o.inv   = 1'b1;
        OP_SETM:  ctrl_o.set   = 1'b1;
        default:  ctrl_o       = '0;
      endcase
    end
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pe_ctrl_t          ctrl_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] shift_i,
  output logic [DATA_W-1:0] value_o,
  output logic              flag_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] val_q;
  logic              flag_q;
  logic [DATA_W-1:0] scaled;

  // fixed-point product, keep the integer-aligned middle slice
  assign scaled = DATA_W'(({{DATA_W{1'b0}}, val_q} * {{DATA_W{1'b0}}, imm_i}) >> FRAC_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
    end else if (ctrl_i.shift) begin
      val_q <= shift_i;
    end else if (ctrl_i.mul && flag_q) begin
      val_q <= scaled;
    end
  end

  // compare writes the flag regardless of current enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b1;
    end else if (ctrl_i.cmp) begin
      flag_q <= (val_q > imm_i);
    end else if (ctrl_i.inv) begin
      flag_q <= ~flag_q;
    end else if (ctrl_i.set) begin
      flag_q <= 1'b1;
    end
  end

  assign value_o = val_q;
  assign flag_o  = flag_q;

  p_cmp_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.cmp |=> flag_o == ($past(value_o) > $past(imm_i)));
  p_hold_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.mul && !flag_o) |=> $stable(value_o));
  p_inv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.inv |=> flag_o != $past(flag_o));
  p_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.set |=> flag_o);
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i == '0) |=> ($stable(value_o) && $stable(flag_o)));
  p_mul_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.mul && flag_o && imm_i == (DATA_W'(1) << FRAC_W)) |=> $stable(value_o));
  initial assert (PROD_W > FRAC_W + DATA_W - 1);
endmodule

// File: rtl/simd_any.sv
module simd_any #(
  parameter int unsigned NUM_PE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PE-1:0] flags_i,
  output logic              any_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) any_o <= 1'b1;
    else         any_o <= |flags_i;
  end
endmodule

// File: rtl/simd_array.sv
module simd_array
  import simd_pkg::*;
#(
  parameter int unsigned NUM_PE = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [2:0]        opcode_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] ser_data_i,
  output logic [DATA_W-1:0] ser_data_o,
  output logic              any_en_o
);
  pe_ctrl_t          ctrl;
  logic [DATA_W-1:0] pe_val [NUM_PE];
  logic [NUM_PE-1:0] pe_flag;

  simd_decode i_decode (
    .valid_i (instr_valid_i),
    .op_i    (opcode_i),
    .ctrl_o  (ctrl)
  );

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    logic [DATA_W-1:0] chain_in;
    if (g == 0) begin : g_head
      assign chain_in = ser_data_i;
    end else begin : g_link
      assign chain_in = pe_val[g-1];
    end
    simd_pe #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) i_pe (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ctrl_i  (ctrl),
      .imm_i   (imm_i),
      .shift_i (chain_in),
      .value_o (pe_val[g]),
      .flag_o  (pe_flag[g])
    );
  end

  simd_any #(.NUM_PE(NUM_PE)) i_any (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (pe_flag),
    .any_o   (any_en_o)
  );

  assign ser_data_o = pe_val[NUM_PE-1];

  p_shift_head_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.shift |=> pe_val[0] == $past(ser_data_i));
  p_shift_tail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.shift |=> ser_data_o == $past(pe_val[NUM_PE-2]));
  p_any_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_flag == '0) |=> !any_en_o);
  p_any_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_flag != '0) |=> any_en_o);
endmodule

// File: tb/test_simd_array.sv
module test_simd_array;
  localparam int N = 8;
  localparam logic [31:0] THR = 32'd100000;
  localparam logic [31:0] K_HI = 32'd68813;
  localparam logic [31:0] K_LO = 32'd72090;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [2:0] opcode = 3'd0;
  logic [31:0] imm = '0;
  logic [31:0] ser_in = '0;
  logic [31:0] ser_out;
  logic any_en;

  int checks = 0;
  int fails = 0;
  logic [31:0] model_v [N];
  logic        model_f [N];
  logic [31:0] rec [N];

  always #5 clk = ~clk;

  simd_array i_simd_array (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .opcode_i(opcode),
    .imm_i(imm), .ser_data_i(ser_in), .ser_data_o(ser_out), .any_en_o(any_en)
  );

  function automatic logic [31:0] mulq(input logic [31:0] v, input logic [31:0] k);
    logic [63:0] p;
    p = {32'd0, v} * {32'd0, k};
    return p[47:16];
  endfunction

  function automatic logic model_any();
    logic a = 1'b0;
    for (int k = 0; k < N; k++) a |= model_f[k];
    return a;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [2:0] op, input logic [31:0] im);
    @(negedge clk);
    valid = v; opcode = op; imm = im;
    @(negedge clk);
    valid = 1'b0; opcode = 3'd0;
    if (v) begin
      case (op)
        3'd1: begin
          for (int k = N - 1; k > 0; k--) model_v[k] = model_v[k-1];
          model_v[0] = ser_in;
        end
        3'd2: for (int k = 0; k < N; k++) model_f[k] = model_v[k] > im;
        3'd3: for (int k = 0; k < N; k++) if (model_f[k]) model_v[k] = mulq(model_v[k], im);
        3'd4: for (int k = 0; k < N; k++) model_f[k] = ~model_f[k];
        3'd5: for (int k = 0; k < N; k++) model_f[k] = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic load_recs();
    for (int k = N - 1; k >= 0; k--) begin
      ser_in = rec[k];
      issue(1'b1, 3'd1, 32'd0);
    end
  endtask

  // unload by rotation: every PE passes the serial output, array is restored
  task automatic rotate_check(input string req);
    for (int m = 0; m < N; m++) begin
      chk(req, ser_out, model_v[N-1]);
      ser_in = ser_out;
      issue(1'b1, 3'd1, 32'd0);
    end
  endtask

  task automatic any_check(input string req);
    @(negedge clk);
    chk(req, {31'd0, any_en}, {31'd0, model_any()});
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin model_v[k] = '0; model_f[k] = 1'b1; end
    #23;
    chk("R1 ser_out", ser_out, 32'd0);
    chk("R1 any_en", {31'd0, any_en}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 any_en after release", {31'd0, any_en}, 32'd1);
    rotate_check("R1 values");

    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < N; k++) begin
        case (p)
          0: rec[k] = THR + 32'(k) - 32'd4;
          1: rec[k] = 32'(k) * 32'd37000;
          2: rec[k] = 32'hFFFF_FFF0 - 32'(k) * 32'd100000;
          default: rec[k] = (32'(k) * 32'h9E37_79B9 + 32'(p) * 32'd12345) >> k;
        endcase
      end
      load_recs();
      rotate_check("R2 load");
      issue(1'b1, 3'd5, 32'd0);
      issue(1'b1, 3'd2, THR);
      any_check("R9 after cmp");
      issue(1'b1, 3'd3, K_HI);
      issue(1'b1, 3'd4, 32'd0);
      any_check("R9 after inv");
      issue(1'b1, 3'd3, K_LO);
      for (int k = 0; k < N; k++) begin
        logic [31:0] e;
        e = (rec[k] > THR) ? mulq(rec[k], K_HI) : mulq(rec[k], K_LO);
        chk("R10 model", model_v[k], e);
      end
      rotate_check("R10 R4 R5 per-PE");
    end

    // all disabled: multiply must not touch anything
    issue(1'b1, 3'd2, 32'hFFFF_FFFF);
    any_check("R9 none enabled");
    issue(1'b1, 3'd3, 32'h0003_0000);
    rotate_check("R5 disabled hold");
    // shift works with all flags clear
    ser_in = 32'hA5A5_0001;
    issue(1'b1, 3'd1, 32'd0);
    chk("R2 shift while disabled", model_v[0], 32'hA5A5_0001);
    rotate_check("R2 shift ignores mask");

    // back-to-back cmp (clear all) then inv, reduction lags one cycle
    issue(1'b1, 3'd5, 32'd0);
    @(negedge clk);
    valid = 1'b1; opcode = 3'd2; imm = 32'hFFFF_FFFF;
    @(negedge clk);
    opcode = 3'd4;
    chk("R9 lag: flags still set before cmp", {31'd0, any_en}, 32'd1);
    @(negedge clk);
    valid = 1'b0; opcode = 3'd0;
    chk("R9 lag: cmp cleared flags", {31'd0, any_en}, 32'd0);
    for (int k = 0; k < N; k++) model_f[k] = 1'b1;
    @(negedge clk);
    chk("R6 R9 inv after cmp", {31'd0, any_en}, 32'd1);

    // compare writes disabled PEs
    issue(1'b1, 3'd2, 32'hFFFF_FFFF);
    issue(1'b1, 3'd2, 32'd0);
    any_check("R3 cmp on disabled PEs");
    issue(1'b1, 3'd3, 32'h0002_0000);
    rotate_check("R3 R4 doubled where nonzero");

    // invert twice returns the mask
    issue(1'b1, 3'd4, 32'd0);
    any_check("R6 inverted");
    issue(1'b1, 3'd4, 32'd0);
    any_check("R6 restored");

    // no-effect codes
    issue(1'b0, 3'd3, 32'h0004_0000);
    issue(1'b0, 3'd4, 32'd0);
    issue(1'b1, 3'd0, 32'h0004_0000);
    issue(1'b1, 3'd6, 32'h0004_0000);
    issue(1'b1, 3'd7, 32'h0004_0000);
    any_check("R8 flags unchanged");
    rotate_check("R8 values unchanged");

    issue(1'b1, 3'd2, 32'hFFFF_FFFF);
    issue(1'b1, 3'd5, 32'd0);
    any_check("R7 setall");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule